// File: doc/BRIEF.md
# SPI Register Access Slave

This block lets an external SPI master read and write a file of 128 eight-bit registers. The master lowers chip select and sends a command byte, then a register address byte, then any number of data bytes. Each data byte moves the address on by one, and the address wraps from 127 back to 0. A transfer ends when chip select rises. Only SPI mode 0 is used: bits travel most significant first, the slave samples MOSI on the rising SCLK edge, and MISO changes after the falling edge.

The serial inputs are oversampled in the system clock domain through two-stage synchronizers, so SCLK must stay well below the system clock rate. The register file sits outside the block. The block drives its address, write data and write strobe, and it reads the selected word back through a combinational read port. Register 1, bit 0 is a start flag. Once it holds 1, a write through this interface cannot clear it.

Top module: `spi_regfile_slave`

## Requirements
- R1: After reset, MISO is 0 and the write strobe is low.
- R2: Command 0x02, an address byte and one data byte write that byte to the addressed register.
- R3: In a write burst, each further data byte goes to the next address, wrapping from 127 to 0.
- R4: Command 0x03 and an address byte return that register's content on MISO, most significant bit first, during the next byte.
- R5: In a read burst, each further byte returns the next register, wrapping from 127 to 0.
- R6: Any other command byte causes no write for the rest of the transfer, and MISO stays 0.
- R7: Raising chip select in the middle of a byte drops that partial byte without writing it, and the next transfer begins with a command byte.
- R8: Once register 1 bit 0 is 1, a write to register 1 leaves that bit at 1. The other bits take the written value.
- R9: Only the low seven bits of the address byte select the register. Bit 7 is ignored.
- R10: The write strobe is high for exactly one system clock cycle for each data byte written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | SPI serial clock (mode 0) |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |
| rf_addr | output | 7 | Register file address |
| rf_wdata | output | 8 | Register file write data |
| rf_we | output | 1 | Register file write strobe |
| rf_rdata | input | 8 | Register file read data for rf_addr |

## Verification
The bench runs directed single-byte writes and reads, which show that command decode and bit order are correct. Bursts that start at 125 and 126 separate a correct address wrap from an overrun past 127. An unknown command, a chip select that rises in mid-byte, and an address byte with its top bit set each cover a case where the byte must be ignored. Repeated writes to register 1 show whether the start flag holds after it is set. Random mixed read and write bursts, of random lengths and at random addresses, are then checked against a bench-side model of the register contents.

// File: rtl/spi_regfile_slave.sv
module spi_regfile_slave #(
  parameter int AW = 7,
  parameter int DW = 8,
  parameter logic [AW-1:0] START_REG = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk,
  input  logic          cs_n,
  input  logic          mosi,
  output logic          miso,
  output logic [AW-1:0] rf_addr,
  output logic [DW-1:0] rf_wdata,
  output logic          rf_we,
  input  logic [DW-1:0] rf_rdata
);
  localparam logic [7:0] CMD_RD = 8'h03;
  localparam logic [7:0] CMD_WR = 8'h02;

  typedef enum logic [1:0] {PH_CMD, PH_ADDR, PH_DATA, PH_IGN} ph_t;

  logic [1:0] sclk_q, cs_q, mosi_q;
  logic       sclk_d;
  logic       cs_s, rise, fall;
  ph_t        ph;
  logic       rd;
  logic [2:0] cnt;
  logic [6:0] sr;
  logic [7:0] nb;
  logic [DW-1:0] tx, wd;
  logic [AW-1:0] addr;
  logic       ld, we_r, miso_r;

  assign cs_s = cs_q[1];
  assign rise = sclk_q[1] & ~sclk_d;
  assign fall = ~sclk_q[1] & sclk_d;
  assign nb   = {sr, mosi_q[1]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_q <= '0; cs_q <= '1; mosi_q <= '0; sclk_d <= 1'b0;
    end else begin
      sclk_q <= {sclk_q[0], sclk};
      cs_q   <= {cs_q[0], cs_n};
      mosi_q <= {mosi_q[0], mosi};
      sclk_d <= sclk_q[1];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ph <= PH_CMD; rd <= 1'b0; cnt <= '0; sr <= '0; tx <= '0;
      wd <= '0; addr <= '0; ld <= 1'b0; we_r <= 1'b0; miso_r <= 1'b0;
    end else if (cs_s) begin
      ph <= PH_CMD; cnt <= '0; ld <= 1'b0; we_r <= 1'b0; miso_r <= 1'b0;
    end else begin
      we_r <= 1'b0;
      ld   <= 1'b0;
      if (we_r) addr <= addr + 1'b1;
      if (ld) tx <= rf_rdata;
      if (rise) begin
        sr  <= nb[6:0];
        cnt <= cnt + 3'd1;
        if (cnt == 3'd7)
          case (ph)
            PH_CMD: begin
              rd <= (nb == CMD_RD);
              ph <= (nb == CMD_RD || nb == CMD_WR) ? PH_ADDR : PH_IGN;
            end
            PH_ADDR: begin
              addr <= nb[AW-1:0];
              ph   <= PH_DATA;
              ld   <= rd;
            end
            PH_DATA:
              if (rd) begin
                addr <= addr + 1'b1;
                ld   <= 1'b1;
              end else begin
                wd   <= nb[DW-1:0];
                we_r <= 1'b1;
              end
            default: ;
          endcase
      end
      if (fall && ph == PH_DATA && rd) begin
        miso_r <= tx[DW-1];
        tx     <= {tx[DW-2:0], 1'b0};
      end
    end

  assign miso     = miso_r;
  assign rf_addr  = addr;
  assign rf_we    = we_r;
  assign rf_wdata = {wd[DW-1:1], wd[0] | ((addr == START_REG) & rf_rdata[0])};
endmodule

// File: rtl/spi_regfile_slave_chk.sv
module spi_regfile_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_s,
  input logic [1:0] ph,
  input logic       miso,
  input logic [6:0] rf_addr,
  input logic [7:0] rf_wdata,
  input logic [7:0] rf_rdata,
  input logic       rf_we
);
  p_we_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |=> !rf_we);
  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we && !cs_s) |=> rf_addr == $past(rf_addr) + 7'd1);
  p_miso_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> !miso);
  p_ignore_nowr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == 2'd3 && $past(ph) == 2'd3) |-> !rf_we);
  p_ignore_miso_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == 2'd3 && $past(ph) == 2'd3) |-> !miso);
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we && rf_addr == 7'd1 && rf_rdata[0]) |-> rf_wdata[0]);
endmodule

bind spi_regfile_slave spi_regfile_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .ph(ph), .miso(miso),
  .rf_addr(rf_addr), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata), .rf_we(rf_we)
);

// File: tb/test_spi_regfile_slave.sv
module test_spi_regfile_slave;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, rf_we;
  logic [6:0] rf_addr;
  logic [7:0] rf_wdata, rf_rdata;
  logic [7:0] mem [128];
  logic [7:0] expm [128];
  logic [7:0] tbuf [8];
  logic [7:0] rbuf [8];
  int checks = 0, errors = 0, cyc = 0, we_pulses = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  spi_regfile_slave i_spi_regfile_slave (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .miso(miso), .rf_addr(rf_addr), .rf_wdata(rf_wdata), .rf_we(rf_we),
    .rf_rdata(rf_rdata)
  );

  assign rf_rdata = mem[rf_addr];
  always @(posedge clk) begin
    if (rf_we) begin mem[rf_addr] <= rf_wdata; we_pulses <= we_pulses + 1; end
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      errors = errors + 1;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [7:0] sticky(input logic [6:0] a, input logic [7:0] d);
    return (a == 7'd1) ? (d | {7'b0, expm[1][0]}) : d;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_byte(input logic [7:0] b, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      wclk(1); mosi = b[i];
      wclk(7); r[i] = miso; sclk = 1'b1;
      wclk(8); sclk = 1'b0;
    end
  endtask

  task automatic txn(input logic [7:0] cmd, input logic [7:0] a, input int n);
    logic [7:0] r;
    wclk(1); cs_n = 1'b0; wclk(8);
    spi_byte(cmd, r);
    spi_byte(a, r);
    for (int k = 0; k < n; k++) begin spi_byte(tbuf[k], r); rbuf[k] = r; end
    wclk(8); cs_n = 1'b1; wclk(10);
  endtask

  task automatic do_write(input logic [6:0] a, input int n, input string req);
    for (int k = 0; k < n; k++) begin
      logic [6:0] ak = a + 7'(k);
      expm[ak] = sticky(ak, tbuf[k]);
    end
    txn(8'h02, {1'b0, a}, n);
    for (int k = 0; k < n; k++) chk(req, mem[a + 7'(k)], expm[a + 7'(k)]);
  endtask

  task automatic do_read(input logic [6:0] a, input int n, input string req);
    for (int k = 0; k < n; k++) tbuf[k] = 8'h00;
    txn(8'h03, {1'b0, a}, n);
    for (int k = 0; k < n; k++) chk(req, rbuf[k], expm[a + 7'(k)]);
  endtask

  initial begin
    logic [7:0] r;
    int p0;
    void'($urandom(32'h5A17));
    for (int i = 0; i < 128; i++) begin
      mem[i] = 8'($urandom);
      if (i == 1) mem[i][0] = 1'b0;
      expm[i] = mem[i];
    end
    wclk(5); rst_n = 1'b1; wclk(3);
    chk("R1 miso", miso, 0);
    chk("R1 we", rf_we, 0);

    tbuf[0] = 8'hA5; do_write(7'd5, 1, "R2 single write");
    do_read(7'd5, 1, "R4 single read");
    tbuf[0] = 8'h3C; p0 = we_pulses; do_write(7'd40, 1, "R2 write");
    chk("R10 one strobe per byte", we_pulses - p0, 1);

    for (int k = 0; k < 4; k++) tbuf[k] = 8'(8'h10 + k);
    p0 = we_pulses; do_write(7'd126, 4, "R3 burst wrap");
    chk("R10 strobe count burst", we_pulses - p0, 4);
    do_read(7'd125, 5, "R5 burst read wrap");

    tbuf[0] = 8'hFF; tbuf[1] = 8'hFF;
    p0 = we_pulses;
    txn(8'h5A, 8'h05, 2);
    chk("R6 no write", we_pulses - p0, 0);
    chk("R6 miso zero", {rbuf[0], rbuf[1]}, 0);
    chk("R6 reg kept", mem[5], expm[5]);

    p0 = we_pulses;
    wclk(1); cs_n = 1'b0; wclk(8);
    spi_byte(8'h02, r); spi_byte(8'h0A, r);
    for (int i = 7; i >= 4; i--) begin
      wclk(1); mosi = 1'b1; wclk(7); sclk = 1'b1; wclk(8); sclk = 1'b0;
    end
    wclk(8); cs_n = 1'b1; wclk(10);
    chk("R7 partial dropped", we_pulses - p0, 0);
    chk("R7 reg kept", mem[10], expm[10]);
    do_read(7'd10, 1, "R7 next txn decodes command");

    tbuf[0] = 8'h81; do_write(7'd1, 1, "R8 set start");
    tbuf[0] = 8'h40; do_write(7'd1, 1, "R8 start stays");
    chk("R8 bit0", mem[1][0], 1);
    do_read(7'd1, 1, "R8 readback");

    tbuf[0] = 8'h77; expm[5] = 8'h77;
    txn(8'h02, 8'h85, 1);
    chk("R9 top addr bit ignored", mem[5], 8'h77);
    for (int k = 0; k < 1; k++) tbuf[k] = 8'h00;
    txn(8'h03, 8'h85, 1);
    chk("R9 read high addr", rbuf[0], 8'h77);

    for (int t = 0; t < 30; t++) begin
      logic [6:0] a = 7'($urandom_range(0, 127));
      int n = $urandom_range(1, 6);
      if ($urandom_range(0, 1) == 1) begin
        for (int k = 0; k < n; k++) tbuf[k] = 8'($urandom);
        do_write(a, n, "R3 random burst write");
      end else do_read(a, n, "R5 random burst read");
    end

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule